// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous burst memory. On any rising clock edge where either of two address strobes is high, it captures a full external address and starts a new burst at position zero. After that, the low two address bits come from an internal burst counter. The counter moves forward only on cycles where the advance input is high.

The upper address bits stay frozen for the whole burst, so a burst always stays inside its aligned group of four words. A mode input, sampled on the load edge, picks one of two step orders. In linear order the low bits count up from the start value and wrap. In interleaved order the low bits are the start value XOR the burst position.

A new address can be loaded on every cycle, so a controller that never uses the burst function loses no cycles. Both outputs come straight from registers and the order-mapping logic, with no added latency beyond the load or advance edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `addr_out` becomes 0 and `burst_pos` becomes 0.
- R2: A clock edge with `strobe_a` or `strobe_b` high loads `ext_addr`: after that edge `addr_out` equals the `ext_addr` sampled there, and `burst_pos` is 0.
- R3: Loads on consecutive cycles each take effect on their own edge, with no lost cycle.
- R4: An edge with `advance` high and both strobes low increments `burst_pos` by 1, wrapping from 3 to 0.
- R5: An edge with both strobes low and `advance` low leaves `addr_out` and `burst_pos` unchanged.
- R6: When a strobe and `advance` are both high on the same edge, the load wins and `burst_pos` becomes 0.
- R7: With linear order (`order_lin` = 1 at the load edge), `addr_out[1:0]` equals (start low bits + `burst_pos`) mod 4.
- R8: With interleaved order (`order_lin` = 0 at the load edge, the default level), `addr_out[1:0]` equals start low bits XOR `burst_pos`.
- R9: `addr_out[ADDR_W-1:2]` never changes except on a load edge, so every burst wraps inside its aligned group of four.
- R10: `order_lin` is sampled only on load edges. Changing it during a burst has no effect on the sequence until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_a | input | 1 | First address strobe; high loads `ext_addr` |
| strobe_b | input | 1 | Second address strobe; same effect as `strobe_a` |
| advance | input | 1 | Steps the burst counter when no strobe is high |
| order_lin | input | 1 | 1 selects linear order, 0 selects interleaved; sampled on load |
| ext_addr | input | ADDR_W | External word address to load |
| addr_out | output | ADDR_W | Current word address |
| burst_pos | output | 2 | Position within the burst, 0 to 3 |

## Verification
Directed sequences cover several cases:
- A load followed by four and five advances, in each order and from every start low value. This separates the linear wrap from the XOR order and shows the wrap back to the start.
- Strobe-with-advance cycles, which show the load has priority.
- Idle gaps between advances, which show the hold behaviour.
- A toggle of `order_lin` in mid-burst, which shows the order is latched at load.
- Back-to-back loads on alternating strobes, which show that each strobe loads on its own edge.

A long constrained-random run then mixes all inputs. Each cycle is compared against a bench model built from the requirements.

// File: rtl/burst_pkg.sv
// Package: shared types for the burst address sequence generator.
// Assumes: a one-bit order select where 0 is the default (interleaved) level.
package burst_pkg;

    typedef enum logic {
        ORD_XOR    = 1'b0,
        ORD_LINEAR = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_load_reg.sv
// Module: burst_load_reg
// Holds the start address and the step order captured at the last load.
// Assumes: load is the OR of all strobes; reset is synchronous, active low.
module burst_load_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_in,
    output logic [ADDR_W-1:0] base_q,
    output burst_order_e      order_q
);

    // Capture start address and order on a load edge; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_XOR;
        end else if (load) begin
            base_q  <= addr_in;
            order_q <= burst_order_e'(order_in);
        end
    end

endmodule

// File: rtl/burst_pos_counter.sv
// Module: burst_pos_counter
// Position counter inside a burst: cleared on load, stepped on advance.
// Assumes: load has priority over step; wraps modulo 2**CNT_W.
module burst_pos_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] pos_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Clear on load, increment on step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (load) begin
            pos_q <= '0;
        end else if (step) begin
            pos_q <= pos_q + ONE;
        end
    end

endmodule

// File: rtl/burst_low_map.sv
// Module: burst_low_map
// Maps the start low bits and burst position to the current low address bits.
// Assumes: linear order adds modulo 2**CNT_W; the other order XORs bitwise.
module burst_low_map
    import burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_low,
    input  logic [CNT_W-1:0] pos,
    input  burst_order_e     order,
    output logic [CNT_W-1:0] low_out
);

    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] xor_low;

    // Linear order: wrap-around sum within the aligned group.
    always_comb lin_low = start_low + pos;

    // Interleaved order: one XOR per address bit.
    for (genvar b = 0; b < CNT_W; b++) begin : g_xor
        assign xor_low[b] = start_low[b] ^ pos[b];
    end

    // Pick the order latched at load time.
    always_comb low_out = (order == ORD_LINEAR) ? lin_low : xor_low;

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst word-address generator: two load strobes, an advance gate, and
// linear or interleaved stepping of the low CNT_W bits.
// Assumes: ADDR_W > CNT_W; all inputs synchronous to clk; reset active low.
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic              advance,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_out,
    output logic [CNT_W-1:0]  burst_pos
);

    logic              load;
    logic              step;
    logic [ADDR_W-1:0] base_q;
    burst_order_e      order_q;
    logic [CNT_W-1:0]  low_bits;

    // Either strobe loads; advance steps only without a strobe.
    always_comb begin
        load = strobe_a | strobe_b;
        step = advance & ~load;
    end

    burst_load_reg #(.ADDR_W(ADDR_W)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr_in  (ext_addr),
        .order_in (order_lin),
        .base_q   (base_q),
        .order_q  (order_q)
    );

    burst_pos_counter #(.CNT_W(CNT_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .pos_q (burst_pos)
    );

    burst_low_map #(.CNT_W(CNT_W)) u_map (
        .start_low (base_q[CNT_W-1:0]),
        .pos       (burst_pos),
        .order     (order_q),
        .low_out   (low_bits)
    );

    // Upper bits come from the loaded address; low bits from the map.
    always_comb addr_out = {base_q[ADDR_W-1:CNT_W], low_bits};

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Assertion checker bound to burst_addr_seq; watches ports only.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_a,
    input logic              strobe_b,
    input logic              advance,
    input logic              order_lin,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] addr_out,
    input logic [CNT_W-1:0]  burst_pos
);

    logic             any_strobe;
    logic             lin_seen;
    logic [CNT_W-1:0] lin_key;
    logic [CNT_W-1:0] xor_key;

    always_comb begin
        any_strobe = strobe_a | strobe_b;
        lin_key    = CNT_W'(addr_out[CNT_W-1:0] - burst_pos);
        xor_key    = addr_out[CNT_W-1:0] ^ burst_pos;
    end

    // Independent record of the order chosen at the last load.
    always_ff @(posedge clk) begin
        if (!rst_n)          lin_seen <= 1'b0;
        else if (any_strobe) lin_seen <= order_lin;
    end

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> (addr_out == $past(ext_addr)) && (burst_pos == '0));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && advance) |=> burst_pos == CNT_W'($past(burst_pos) + 1'b1));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && !advance) |=> $stable(addr_out) && $stable(burst_pos));

    a_r6_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strobe && advance) |=> burst_pos == '0);

    a_r7_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && lin_seen) |=> lin_key == $past(lin_key));

    a_r8_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && !lin_seen) |=> xor_key == $past(xor_key));

    a_r9_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> $stable(addr_out[ADDR_W-1:CNT_W]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_burst_addr_seq.sv
// Bench for burst_addr_seq: directed corners plus seeded random stimulus,
// compared against a model written from the requirements.
module test_burst_addr_seq;

    localparam int ADDR_W    = 20;
    localparam int CNT_W     = 2;
    localparam int HALF_NS   = 10;
    localparam int MAX_CYC   = 200000;
    localparam int RAND_CYC  = 3000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              strobe_a, strobe_b, advance, order_lin;
    logic [ADDR_W-1:0] ext_addr;
    logic [ADDR_W-1:0] addr_out;
    logic [CNT_W-1:0]  burst_pos;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    // Bench model state.
    logic [ADDR_W-1:0] m_base;
    logic              m_lin;
    logic [CNT_W-1:0]  m_pos;

    always #(HALF_NS) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
        .advance(advance), .order_lin(order_lin), .ext_addr(ext_addr),
        .addr_out(addr_out), .burst_pos(burst_pos)
    );

    function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] base,
                                                   logic lin, logic [CNT_W-1:0] pos);
        logic [CNT_W-1:0] lo;
        lo = lin ? CNT_W'(base[CNT_W-1:0] + pos) : (base[CNT_W-1:0] ^ pos);
        return {base[ADDR_W-1:CNT_W], lo};
    endfunction

    task automatic check(string req);
        logic [ADDR_W-1:0] ea;
        ea = exp_addr(m_base, m_lin, m_pos);
        n_cmp++;
        if (addr_out !== ea || burst_pos !== m_pos) begin
            n_bad++;
            $display("FAIL %s: addr=%h pos=%0d expected addr=%h pos=%0d",
                     req, addr_out, burst_pos, ea, m_pos);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, check 5 ns later.
    task automatic cyc(logic sa, logic sb, logic adv, logic ol,
                       logic [ADDR_W-1:0] a, string req);
        @(negedge clk);
        strobe_a = sa; strobe_b = sb; advance = adv; order_lin = ol; ext_addr = a;
        @(posedge clk);
        if (!rst_n) begin
            m_base = '0; m_lin = 1'b0; m_pos = '0;
        end else if (sa || sb) begin
            m_base = a; m_lin = ol; m_pos = '0;
        end else if (adv) begin
            m_pos = m_pos + CNT_W'(1);
        end
        #5;
        check(req);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(2 * HALF_NS * MAX_CYC);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        strobe_a = 0; strobe_b = 0; advance = 0; order_lin = 0; ext_addr = '0;
        rst_n = 1'b0;
        m_base = '0; m_lin = 1'b0; m_pos = '0;
        cyc(1, 0, 1, 1, 20'hABCDE, "R1");
        cyc(0, 0, 1, 1, 20'h12345, "R1");
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, '0, "R1");

        // R7 and R8: full bursts plus one extra advance, every start low value.
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 2; o++) begin
                cyc(1, 0, 0, o[0], {18'h2A5F1, s[1:0]}, "R2");
                for (int k = 0; k < 5; k++)
                    cyc(0, 0, 1, o[0], 20'h0, o[0] ? "R7" : "R8");
            end
        end

        // R4 and R9: wrap stays inside the aligned group at an upper-bit boundary.
        cyc(0, 1, 0, 1, 20'h0FFFF, "R2");
        for (int k = 0; k < 4; k++) cyc(0, 0, 1, 1, 20'hFFFFF, "R9");

        // R5: idle gaps between advances.
        cyc(1, 0, 0, 0, 20'h55556, "R2");
        cyc(0, 0, 0, 1, 20'h11111, "R5");
        cyc(0, 0, 1, 0, 20'h22222, "R4");
        cyc(0, 0, 0, 0, 20'h33333, "R5");
        cyc(0, 0, 0, 1, 20'h44444, "R5");

        // R6: strobe together with advance.
        cyc(0, 0, 1, 0, 20'h0, "R4");
        cyc(0, 1, 1, 1, 20'h7777B, "R6");
        cyc(1, 1, 1, 0, 20'h00002, "R6");

        // R10: order toggled mid-burst is ignored.
        cyc(1, 0, 0, 1, 20'h9ABC1, "R2");
        cyc(0, 0, 1, 0, 20'h0, "R10");
        cyc(0, 0, 1, 1, 20'h0, "R10");
        cyc(0, 0, 1, 0, 20'h0, "R10");
        cyc(1, 0, 0, 0, 20'h9ABC1, "R2");
        cyc(0, 0, 1, 1, 20'h0, "R10");
        cyc(0, 0, 1, 1, 20'h0, "R10");

        // R3: back-to-back loads on alternating strobes.
        for (int k = 0; k < 8; k++)
            cyc(k[0], ~k[0], 1, k[1], 20'(32'h10000 + k * 32'h1357), "R3");

        // Random mix: strobes rarer than advances.
        for (int k = 0; k < RAND_CYC; k++) begin
            automatic int r = $urandom_range(0, 99);
            cyc(r < 12, (r >= 12 && r < 20), $urandom_range(0, 99) < 60,
                1'($urandom_range(0, 1)), 20'($urandom()), "R2/R4/R5/R7/R8");
        end

        // R1: reset mid-burst returns to zero.
        rst_n = 1'b0;
        cyc(0, 0, 1, 1, 20'h0, "R1");
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 20'h0, "R1");

        done = 1'b1;
        summary();
    end

endmodule